// File: doc/BRIEF.md
# Three-Entry Fetch Target Cache

This block is a tiny fully associative cache of branch targets that sits next to the fetch stage of a pipelined core. Each of its three slots holds an 8-bit tag and a 32-bit target address. The tag is taken from the low bits of a branch's address. On every falling clock edge the block compares the current fetch address with the stored tags. It then registers either the matching target with a hit flag, or zero with no hit.

The execute stage feeds back each resolving branch. It supplies the return address carried with the branch (branch address plus four), the computed target, whether the branch was taken, and whether fetch had predicted it. A taken branch that fetch did not predict, and whose address is not cached yet, is written into the front slot. The older slots move back one place, and the oldest is dropped. Slots are kept in recency order. A hit in the middle slot swaps it with the front slot. A hit in the back slot moves it to the front.

On each falling edge the block takes exactly one action: FILL (insert a new branch), HIT_FRONT, HIT_MID, HIT_BACK, or MISS. FILL has priority over every lookup. A synchronous reset clears all slots and both outputs. After reset the action is chosen again on each following edge.

Top module: `fetch_target_cache`

## Requirements
- R1: With `rst` high at a falling edge, every slot becomes invalid and `pred_hit`/`pred_target` become 0. No fetch address hits again until a new FILL.
- R2: A fetch address hits a slot when bits [7:0] of the address equal the slot's tag and the slot is valid. Upper address bits do not take part in the match. A tag value of 0x00 is an ordinary tag.
- R3: The resolving branch's address is `res_pc_plus4 - 4`, and its tag is bits [7:0] of that difference, including the borrow out of the low bits.
- R4: FILL occurs when `res_taken`=1, `res_predicted`=0 and the branch tag is in no valid slot. After that edge, slot 0 holds the new tag and `res_target`, the old slot 0 is in slot 1, the old slot 1 is in slot 2, the old slot 2 is lost, and both outputs are 0.
- R5: No FILL occurs when the branch was not taken, was predicted, or its tag is already cached. The lookup then proceeds as usual, and valid tags stay distinct.
- R6: HIT_FRONT (match in slot 0) registers slot 0's target with `pred_hit`=1 and leaves the slot order unchanged.
- R7: HIT_MID (match in slot 1) registers slot 1's target with `pred_hit`=1 and exchanges slots 0 and 1.
- R8: HIT_BACK (match in slot 2) registers slot 2's target with `pred_hit`=1. Slot 2 moves to slot 0, old slot 0 moves to slot 1, and old slot 1 moves to slot 2.
- R9: MISS registers `pred_target`=0 and `pred_hit`=0 and leaves all slots unchanged.
- R10: FILL takes priority over a fetch hit in the same cycle, even when the fetch address matches the tag being inserted.
- R11: State and outputs change only at falling clock edges. A rising edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Address currently being fetched |
| res_pc_plus4 | input | 32 | Return address carried with the resolving branch |
| res_target | input | 32 | Target computed for the resolving branch |
| res_taken | input | 1 | Resolving branch was taken |
| res_predicted | input | 1 | Fetch had predicted the resolving branch taken |
| pred_target | output | 32 | Registered target for the fetch address, 0 when no hit |
| pred_hit | output | 1 | Registered hit flag |

## Verification
The assertions check several rules on every falling edge. After each FILL, HIT_FRONT, HIT_MID, HIT_BACK or MISS, the slot contents and outputs must match what that action prescribes. Valid tags must stay pairwise distinct, at most one slot may match a fetch address, and reset must clear everything. Other behaviours are visible only across several cycles, so only the bench scenarios can show them. These are: eviction order after a chain of promotions, the borrow in the branch-address tag, masking of upper address bits, and outputs holding steady across rising edges. The bench drives directed sequences and a long pseudo-random sweep over a small tag set, and compares every cycle with an arithmetic model of the three-slot list.

// File: rtl/fcache_pkg.sv
package fcache_pkg;
    localparam int SLOTS = 3;

    typedef enum logic [2:0] {
        ACT_FILL,
        ACT_HIT_FRONT,
        ACT_HIT_MID,
        ACT_HIT_BACK,
        ACT_MISS
    } fc_action_e;
endpackage

// File: rtl/fc_tag_match.sv
module fc_tag_match
    import fcache_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [SLOTS-1:0]            vld,
    input  logic [SLOTS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic [SLOTS-1:0]            hits
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        assign hits[s] = vld[s] && (tags[s] == key);
    end
endmodule

// File: rtl/fc_decide.sv
module fc_decide
    import fcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_req,
    input  logic [SLOTS-1:0] res_hits,
    input  logic [SLOTS-1:0] fetch_hits,
    output fc_action_e       act
);
    always_comb begin
        if (fill_req && !(|res_hits))  act = ACT_FILL;
        else if (fetch_hits[0])        act = ACT_HIT_FRONT;
        else if (fetch_hits[1])        act = ACT_HIT_MID;
        else if (fetch_hits[2])        act = ACT_HIT_BACK;
        else                           act = ACT_MISS;
    end

    AST_ONE_FETCH_MATCH: assert property (@(negedge clk) disable iff (rst)
        $onehot0(fetch_hits)); // R2
    AST_ONE_RES_MATCH: assert property (@(negedge clk) disable iff (rst)
        $onehot0(res_hits)); // R5
endmodule

// File: rtl/fc_store.sv
module fc_store
    import fcache_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  fc_action_e                       act,
    input  logic [TAG_W-1:0]                 ins_tag,
    input  logic [ADDR_W-1:0]                ins_tgt,
    output logic [SLOTS-1:0]                 vld_q,
    output logic [SLOTS-1:0][TAG_W-1:0]      tag_q,
    output logic [ADDR_W-1:0]                tgt_o,
    output logic                             hit_o
);
    logic [SLOTS-1:0][ADDR_W-1:0] tgt_q;
    logic [SLOTS-1:0]             vld_d;
    logic [SLOTS-1:0][TAG_W-1:0]  tag_d;
    logic [SLOTS-1:0][ADDR_W-1:0] tgt_d;
    logic [ADDR_W-1:0]            out_tgt_d;
    logic                         out_hit_d;

    // next-state and next-output selection
    always_comb begin
        vld_d     = vld_q;
        tag_d     = tag_q;
        tgt_d     = tgt_q;
        out_tgt_d = '0;
        out_hit_d = 1'b0;
        unique case (act)
            ACT_FILL: begin
                for (int i = SLOTS - 1; i > 0; i--) begin
                    vld_d[i] = vld_q[i-1];
                    tag_d[i] = tag_q[i-1];
                    tgt_d[i] = tgt_q[i-1];
                end
                vld_d[0] = 1'b1;
                tag_d[0] = ins_tag;
                tgt_d[0] = ins_tgt;
            end
            ACT_HIT_FRONT: begin
                out_tgt_d = tgt_q[0];
                out_hit_d = 1'b1;
            end
            ACT_HIT_MID: begin
                tag_d[0] = tag_q[1];  tgt_d[0] = tgt_q[1];  vld_d[0] = vld_q[1];
                tag_d[1] = tag_q[0];  tgt_d[1] = tgt_q[0];  vld_d[1] = vld_q[0];
                out_tgt_d = tgt_q[1];
                out_hit_d = 1'b1;
            end
            ACT_HIT_BACK: begin
                tag_d[0] = tag_q[2];  tgt_d[0] = tgt_q[2];  vld_d[0] = vld_q[2];
                tag_d[1] = tag_q[0];  tgt_d[1] = tgt_q[0];  vld_d[1] = vld_q[0];
                tag_d[2] = tag_q[1];  tgt_d[2] = tgt_q[1];  vld_d[2] = vld_q[1];
                out_tgt_d = tgt_q[2];
                out_hit_d = 1'b1;
            end
            ACT_MISS: begin
            end
            default: begin
            end
        endcase
    end

    // slot state register
    always_ff @(negedge clk) begin
        if (rst) begin
            vld_q <= '0;
            tag_q <= '0;
            tgt_q <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            tgt_q <= tgt_d;
        end
    end

    // output register
    always_ff @(negedge clk) begin
        if (rst) begin
            tgt_o <= '0;
            hit_o <= 1'b0;
        end else begin
            tgt_o <= out_tgt_d;
            hit_o <= out_hit_d;
        end
    end

    AST_RESET_CLEARS: assert property (@(negedge clk)
        rst |=> (vld_q == '0) && !hit_o && (tgt_o == '0)); // R1
    AST_FILL_FRONT: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_FILL) |=> vld_q[0] && (tag_q[0] == $past(ins_tag))
                              && (tgt_q[0] == $past(ins_tgt)) && !hit_o && (tgt_o == '0)); // R4
    AST_FILL_SHIFT: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_FILL) |=> (tag_q[1] == $past(tag_q[0])) && (tag_q[2] == $past(tag_q[1]))
                              && (vld_q[2:1] == $past(vld_q[1:0]))); // R4
    AST_FRONT_KEEP: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_HIT_FRONT) |=> $stable(tag_q) && $stable(tgt_q) && $stable(vld_q)
                                   && hit_o && (tgt_o == tgt_q[0])); // R6
    AST_MID_SWAP: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_HIT_MID) |=> (tag_q[0] == $past(tag_q[1])) && (tag_q[1] == $past(tag_q[0]))
                                 && (tag_q[2] == $past(tag_q[2])) && hit_o && (tgt_o == tgt_q[0])); // R7
    AST_BACK_ROTATE: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_HIT_BACK) |=> (tag_q[0] == $past(tag_q[2])) && (tag_q[1] == $past(tag_q[0]))
                                  && (tag_q[2] == $past(tag_q[1])) && hit_o && (tgt_o == tgt_q[0])); // R8
    AST_MISS_ZERO: assert property (@(negedge clk) disable iff (rst)
        (act == ACT_MISS) |=> !hit_o && (tgt_o == '0) && $stable(tag_q) && $stable(vld_q)); // R9
    AST_NO_DUP_TAG: assert property (@(negedge clk) disable iff (rst)
        !(vld_q[0] && vld_q[1] && tag_q[0] == tag_q[1]) &&
        !(vld_q[0] && vld_q[2] && tag_q[0] == tag_q[2]) &&
        !(vld_q[1] && vld_q[2] && tag_q[1] == tag_q[2])); // R5
endmodule

// File: rtl/fetch_target_cache.sv
module fetch_target_cache
    import fcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 8,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] res_pc_plus4,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_taken,
    input  logic              res_predicted,
    output logic [ADDR_W-1:0] pred_target,
    output logic              pred_hit
);
    localparam logic [TAG_W-1:0] TAG_STEP = TAG_W'(INSTR_BYTES);

    logic [TAG_W-1:0]            fetch_tag;
    logic [TAG_W-1:0]            res_tag;
    logic [SLOTS-1:0]            vld_q;
    logic [SLOTS-1:0][TAG_W-1:0] tag_q;
    logic [SLOTS-1:0]            fetch_hits;
    logic [SLOTS-1:0]            res_hits;
    logic                        fill_req;
    fc_action_e                  act;
    logic                        unused_hi;

    assign fetch_tag = fetch_pc[TAG_W-1:0];
    // low bits of (pc+4)-4 depend only on the low bits of pc+4
    assign res_tag   = res_pc_plus4[TAG_W-1:0] - TAG_STEP;
    assign fill_req  = res_taken && !res_predicted;
    assign unused_hi = ^{fetch_pc[ADDR_W-1:TAG_W], res_pc_plus4[ADDR_W-1:TAG_W]};

    fc_tag_match #(.TAG_W(TAG_W)) u_fetch_match (
        .vld(vld_q), .tags(tag_q), .key(fetch_tag), .hits(fetch_hits)
    );

    fc_tag_match #(.TAG_W(TAG_W)) u_res_match (
        .vld(vld_q), .tags(tag_q), .key(res_tag), .hits(res_hits)
    );

    fc_decide u_decide (
        .clk(clk), .rst(rst), .fill_req(fill_req),
        .res_hits(res_hits), .fetch_hits(fetch_hits), .act(act)
    );

    fc_store #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .act(act),
        .ins_tag(res_tag), .ins_tgt(res_target),
        .vld_q(vld_q), .tag_q(tag_q),
        .tgt_o(pred_target), .hit_o(pred_hit)
    );

    AST_FILL_OUTPUT_ZERO: assert property (@(negedge clk) disable iff (rst)
        (fill_req && !(|res_hits)) |=> !pred_hit && (pred_target == '0)); // R10
endmodule

// File: tb/tb_fetch_target_cache.sv
module tb_fetch_target_cache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, res_pc_plus4, res_target;
    logic        res_taken, res_predicted;
    logic [31:0] pred_target;
    logic        pred_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model of the three slots
    logic [7:0]  m_tag [3];
    logic [31:0] m_tgt [3];
    bit          m_vld [3];
    logic        exp_hit;
    logic [31:0] exp_tgt;
    logic        last_hit;
    logic [31:0] last_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_target_cache dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .res_pc_plus4(res_pc_plus4),
        .res_target(res_target), .res_taken(res_taken), .res_predicted(res_predicted),
        .pred_target(pred_target), .pred_hit(pred_hit)
    );

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic r, input logic [31:0] pc, input logic [31:0] pc4,
                              input logic [31:0] tgt, input logic tk, input logic pd);
        logic [31:0] baddr;
        logic [7:0]  bt, ft, ttag;
        logic [31:0] ttgt;
        bit          present, tv;
        int          slot;
        baddr = pc4 - 32'd4;
        bt = baddr[7:0];
        ft = pc[7:0];
        exp_hit = 1'b0;
        exp_tgt = 32'd0;
        if (r) begin
            for (int i = 0; i < 3; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
            return;
        end
        present = 0;
        for (int i = 0; i < 3; i++) if (m_vld[i] && m_tag[i] == bt) present = 1;
        if (tk && !pd && !present) begin
            for (int i = 2; i > 0; i--) begin
                m_vld[i] = m_vld[i-1]; m_tag[i] = m_tag[i-1]; m_tgt[i] = m_tgt[i-1];
            end
            m_vld[0] = 1; m_tag[0] = bt; m_tgt[0] = tgt;
            return;
        end
        slot = -1;
        for (int i = 0; i < 3; i++) if (slot < 0 && m_vld[i] && m_tag[i] == ft) slot = i;
        if (slot >= 0) begin
            exp_hit = 1'b1;
            exp_tgt = m_tgt[slot];
            ttag = m_tag[slot]; ttgt = m_tgt[slot]; tv = m_vld[slot];
            for (int i = slot; i > 0; i--) begin
                m_vld[i] = m_vld[i-1]; m_tag[i] = m_tag[i-1]; m_tgt[i] = m_tgt[i-1];
            end
            m_vld[0] = tv; m_tag[0] = ttag; m_tgt[0] = ttgt;
        end
    endtask

    // one cycle: drive after the rising edge, check after the falling edge
    task automatic cyc(input logic r, input logic [31:0] pc, input logic [31:0] pc4,
                       input logic [31:0] tgt, input logic tk, input logic pd, input string req);
        @(posedge clk);
        #1;
        check_val("R11 rise", {31'd0, pred_hit}, {31'd0, last_hit});
        check_val("R11 rise", pred_target, last_tgt);
        rst = r; fetch_pc = pc; res_pc_plus4 = pc4; res_target = tgt;
        res_taken = tk; res_predicted = pd;
        model_step(r, pc, pc4, tgt, tk, pd);
        @(negedge clk);
        #1;
        check_val(req, {31'd0, pred_hit}, {31'd0, exp_hit});
        check_val(req, pred_target, exp_tgt);
        last_hit = pred_hit;
        last_tgt = pred_target;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        logic [31:0] bad, fpc;
        rst = 1; fetch_pc = 0; res_pc_plus4 = 0; res_target = 0;
        res_taken = 0; res_predicted = 0;
        last_hit = 0; last_tgt = 0;
        for (int i = 0; i < 3; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
        @(negedge clk); #1;
        last_hit = pred_hit; last_tgt = pred_target;
        cyc(1, 32'h100, 32'h104, 32'h2000, 1, 0, "R1 reset");
        cyc(1, 32'h100, 32'h104, 32'h2000, 1, 0, "R1 reset");
        // fill A (tag 00) while fetching the same address: fill wins
        cyc(0, 32'h100, 32'h104, 32'h2000, 1, 0, "R10 fill over hit");
        cyc(0, 32'h100, 32'h0,   32'h0,    0, 0, "R6 front hit tag 00");
        cyc(0, 32'h5500, 32'h0,  32'h0,    0, 0, "R2 upper bits ignored");
        // predicted / not taken branches do not fill
        cyc(0, 32'h77C, 32'h214, 32'h3000, 1, 1, "R5 predicted no fill");
        cyc(0, 32'h210, 32'h0,   32'h0,    0, 0, "R5 predicted no fill");
        cyc(0, 32'h77C, 32'h214, 32'h3000, 0, 0, "R5 not taken no fill");
        cyc(0, 32'h210, 32'h0,   32'h0,    0, 0, "R5 not taken no fill");
        // fill B and C: order C,B,A
        cyc(0, 32'h77C, 32'h214, 32'h3000, 1, 0, "R4 fill B");
        cyc(0, 32'h77C, 32'h324, 32'h4000, 1, 0, "R4 fill C");
        cyc(0, 32'h100, 32'h0,   32'h0,    0, 0, "R8 back hit A");
        cyc(0, 32'h77C, 32'h434, 32'h5000, 1, 0, "R4 fill D evicts B");
        cyc(0, 32'h210, 32'h0,   32'h0,    0, 0, "R8 B evicted after rotate");
        cyc(0, 32'h320, 32'h0,   32'h0,    0, 0, "R8 back hit C");
        cyc(0, 32'h430, 32'h0,   32'h0,    0, 0, "R7 mid hit D");
        cyc(0, 32'h77C, 32'h544, 32'h6000, 1, 0, "R4 fill E");
        cyc(0, 32'h100, 32'h0,   32'h0,    0, 0, "R7 A evicted after swap");
        cyc(0, 32'h320, 32'h0,   32'h0,    0, 0, "R7 C kept after swap");
        // duplicate branch: no fill, lookup proceeds
        cyc(0, 32'h430, 32'h434, 32'h9999, 1, 0, "R5 duplicate no fill");
        cyc(0, 32'h430, 32'h0,   32'h0,    0, 0, "R5 duplicate target kept");
        // borrow in pc+4 minus 4
        cyc(0, 32'h77C, 32'h402, 32'h7000, 1, 0, "R3 fill borrow");
        cyc(0, 32'h3FE, 32'h0,   32'h0,    0, 0, "R3 tag FE hits");
        cyc(0, 32'h402, 32'h0,   32'h0,    0, 0, "R3 tag 02 misses");
        cyc(0, 32'hABC, 32'h0,   32'h0,    0, 0, "R9 miss zero");
        cyc(0, 32'h3FE, 32'h0,   32'h0,    0, 0, "R9 state unchanged by miss");
        cyc(1, 32'h3FE, 32'h0,   32'h0,    0, 0, "R1 mid-run reset");
        cyc(0, 32'h3FE, 32'h0,   32'h0,    0, 0, "R1 nothing hits after reset");
        // pseudo-random sweep over a small tag set
        lf = 32'h1234_5677;
        for (int n = 0; n < 3000; n++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            bad = {lf[31:20], 12'h0} | {24'h0, 3'(lf[2:0] % 5), 5'h0};
            fpc = {lf[27:16], 12'h0} | {24'h0, 3'(lf[7:5] % 5), 5'h0};
            cyc(lf[19:14] == 6'd0, fpc, bad + 32'd4, {lf[15:4], 4'h0} | 32'h1,
                lf[9], lf[11] & lf[12], "R10 sweep");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule